// File: doc/BRIEF.md
# Vertical Interval Time Code Line Reader

This block extracts vertical interval time code from one chosen scan line of a video field. Upstream logic slices the video into a serial bit stream and separates the sync, so the reader sees a bit strobe with its value, a start-of-line strobe carrying the line number, an end-of-line strobe, a field parity level and a genlock indication. When the selected line starts while the genlock input is high, the reader accepts up to 90 bits from that line. Each line carries nine groups, and each group is a two-bit sync pair followed by eight data bits. The last group holds the check byte. Each completed group's data byte is written out on a one-cycle write strobe with its group index.

At the end-of-line strobe of the line being read, the reader sets two error flags and a valid flag from what arrived. The first error flag shows that the line ended before all 90 bits came in. The second shows that a complete line failed its check, which is the residue of all 90 bits under the generator x^8+1. The valid flag is set only when both error flags are clear. The read line either follows a programmed number or, in search mode, advances through blanking lines 10 to 40 after every line that fails. It wraps to line 10 after line 40 and stays on a line for as long as that line yields valid code.

Top module: `vitc_line_reader`

## Requirements
- R1: While `vid_lock` is low when the target line's `line_start` arrives, no read takes place on that line: no byte write occurs and the three flags keep their values.
- R2: Each complete group of 10 accepted bits produces one `rd_we` pulse, in the cycle after its last bit. On that pulse `rd_addr` is the group index (0 to 8) and `rd_byte` bit j is the group's data bit j, where data bit 0 is the first data bit received after the sync pair.
- R3: If a read line ends with fewer than 90 accepted bits, `no_code` becomes 1 and `crc_err` becomes 0.
- R4: If all 90 bits arrive, `crc_err` is 1 exactly when the 8-bit residue is nonzero. Bit k of the line (k = 0 first) lands at residue position (89-k) mod 8, and the residue is the XOR of all bits that land at each position. `code_ok` is 1 only when `no_code` and `crc_err` are both 0.
- R5: `no_code`, `crc_err` and `code_ok` change only in the cycle after an `line_end` that closes an active read, and they hold at every other time.
- R6: With `search_en` low, `cur_line` takes the value of `prog_line` one cycle later. A read starts only on a `line_start` whose `line_idx` equals `cur_line`.
- R7: With `search_en` high, a read that ends without valid code advances `cur_line` by one. From 40, or from any value outside 10 to 40, it goes to 10. A read that ends with valid code leaves `cur_line` unchanged.
- R8: `status` bit 0 is `no_code`, bit 1 is `crc_err` and bit 2 is `code_ok`. Bit 6 is the field parity, 1 for even and 0 for odd, taken from `field_even` one cycle earlier. All other bits are 0.
- R9: A bit strobe in the same cycle as `line_end` is counted as part of the line. Bits after the 90th are ignored.
- R10: After reset the three flags are 0, `rd_we` is 0 and `cur_line` is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_lock | input | 1 | Genlock achieved |
| field_even | input | 1 | Current field parity, 1 = even |
| line_start | input | 1 | Start-of-line strobe |
| line_idx | input | 6 | Line number valid with `line_start` |
| line_end | input | 1 | End-of-line strobe |
| bit_valid | input | 1 | Sliced bit strobe |
| bit_data | input | 1 | Sliced bit value |
| prog_line | input | 6 | Programmed read line |
| search_en | input | 1 | Search mode enable |
| rd_we | output | 1 | Byte write strobe |
| rd_addr | output | 4 | Group index of the written byte |
| rd_byte | output | 8 | Data byte, first received bit in bit 0 |
| no_code | output | 1 | Line ended before all bits arrived |
| crc_err | output | 1 | Complete line failed its check |
| code_ok | output | 1 | Valid code read |
| cur_line | output | 6 | Line currently being read |
| status | output | 8 | Packed flags and field parity |

## Verification
Two things can fall in the same cycle: the final bit strobe and the end-of-line strobe. This cycle is also where the last byte write and the flag update meet. The bench drives the 90th bit in the same cycle as `line_end` and expects `code_ok` with nine byte writes. A read that closed one bit short would report `no_code` instead. A behavioural reference model made of a bit queue and integer residue arithmetic predicts every output on every clock. It covers both this case and search stepping, because stepping depends on the result that is being decided in that same cycle.

// File: rtl/vitc_line_reader.sv
module vitc_line_reader #(
  parameter int LW    = 6,
  parameter int FIRST = 10,
  parameter int LAST  = 40,
  parameter int NGRP  = 9,
  parameter int DBITS = 8,
  parameter int SYNCB = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vid_lock,
  input  logic                    field_even,
  input  logic                    line_start,
  input  logic [LW-1:0]           line_idx,
  input  logic                    line_end,
  input  logic                    bit_valid,
  input  logic                    bit_data,
  input  logic [LW-1:0]           prog_line,
  input  logic                    search_en,
  output logic                    rd_we,
  output logic [$clog2(NGRP)-1:0] rd_addr,
  output logic [DBITS-1:0]        rd_byte,
  output logic                    no_code,
  output logic                    crc_err,
  output logic                    code_ok,
  output logic [LW-1:0]           cur_line,
  output logic [7:0]              status
);
  localparam int GBITS = SYNCB + DBITS;
  localparam int TOTAL = NGRP * GBITS;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int PW    = $clog2(GBITS);
  localparam int AW    = $clog2(NGRP);

  logic             active, field_q;
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    pos;
  logic [AW-1:0]    grp;
  logic [DBITS-2:0] sh;
  logic [DBITS-1:0] crc;

  wire             take   = active & bit_valid & (cnt < CW'(TOTAL));
  wire [CW-1:0]    cnt_nx = cnt + CW'(take);
  wire [DBITS-1:0] crc_nx = take ? {crc[DBITS-2:0], crc[DBITS-1] ^ bit_data} : crc;
  wire             nc_nx  = cnt_nx < CW'(TOTAL);
  wire             ce_nx  = !nc_nx && (crc_nx != '0);
  wire             ok_nx  = !nc_nx && !ce_nx;
  wire             fin    = active & line_end;
  wire             at_end = pos == PW'(GBITS - 1);
  wire [LW-1:0]    step   = (cur_line >= LW'(LAST) || cur_line < LW'(FIRST)) ?
                            LW'(FIRST) : cur_line + LW'(1);

  assign status = {1'b0, field_q, 3'b000, code_ok, crc_err, no_code};

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      field_q  <= 1'b0;
      cnt      <= '0;
      pos      <= '0;
      grp      <= '0;
      sh       <= '0;
      crc      <= '0;
      rd_we    <= 1'b0;
      rd_addr  <= '0;
      rd_byte  <= '0;
      no_code  <= 1'b0;
      crc_err  <= 1'b0;
      code_ok  <= 1'b0;
      cur_line <= LW'(FIRST);
    end else begin
      rd_we   <= 1'b0;
      field_q <= field_even;
      if (take) begin
        cnt <= cnt_nx;
        crc <= crc_nx;
        if (at_end) begin
          pos     <= '0;
          grp     <= grp + AW'(1);
          rd_we   <= 1'b1;
          rd_addr <= grp;
          rd_byte <= {bit_data, sh};
        end else begin
          pos <= pos + PW'(1);
          if (pos >= PW'(SYNCB)) sh <= {bit_data, sh[DBITS-2:1]};
        end
      end
      if (fin) begin
        no_code <= nc_nx;
        crc_err <= ce_nx;
        code_ok <= ok_nx;
        active  <= 1'b0;
      end
      if (line_start) begin
        active <= vid_lock && (line_idx == cur_line);
        cnt    <= '0;
        pos    <= '0;
        grp    <= '0;
        crc    <= '0;
      end
      if (!search_en) cur_line <= prog_line;
      else if (fin && !ok_nx) cur_line <= step;
    end
  end
endmodule

module vitc_line_reader_chk #(
  parameter int LW   = 6,
  parameter int NGRP = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    line_end,
  input logic                    search_en,
  input logic                    rd_we,
  input logic [$clog2(NGRP)-1:0] rd_addr,
  input logic                    no_code,
  input logic                    crc_err,
  input logic                    code_ok,
  input logic [LW-1:0]           cur_line
);
  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> (rd_addr < NGRP));
  p_write_gap_r2: assert property (@(posedge clk) disable iff (rst)
    rd_we |=> !rd_we);
  p_short_no_crc_r3: assert property (@(posedge clk) disable iff (rst)
    no_code |-> !crc_err);
  p_valid_clean_r4: assert property (@(posedge clk) disable iff (rst)
    code_ok |-> (!no_code && !crc_err));
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable({no_code, crc_err, code_ok}));
  p_search_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (search_en && !line_end) |=> $stable(cur_line));
endmodule

bind vitc_line_reader vitc_line_reader_chk #(.LW(LW), .NGRP(NGRP)) u_chk (.*);

// File: tb/vitc_line_reader_bench.sv
`timescale 1ns/1ps
module vitc_line_reader_bench;
  logic clk = 0, rst = 1;
  logic vid_lock = 0, field_even = 0, line_start = 0, line_end = 0;
  logic bit_valid = 0, bit_data = 0, search_en = 0;
  logic [5:0] line_idx = 0, prog_line = 10;
  logic rd_we, no_code, crc_err, code_ok;
  logic [3:0] rd_addr;
  logic [7:0] rd_byte, status;
  logic [5:0] cur_line;

  int checks = 0, errors = 0, nwrites = 0;
  bit code [0:89];
  logic [7:0] got [0:8];

  always #2.5 clk = ~clk;

  vitc_line_reader u_vitc_line_reader (.*);

  // behavioural reference model
  bit q[$];
  int e_tgt = 10;
  bit m_act = 0, e_we = 0, e_nc = 0, e_ce = 0, e_ok = 0, e_par = 0;
  int e_addr = 0, e_byte = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_tgt = 10; m_act = 0; e_we = 0; e_nc = 0; e_ce = 0; e_ok = 0; e_par = 0;
      q.delete();
    end else begin
      int old_tgt;
      old_tgt = e_tgt;
      e_we = 0;
      if (m_act && bit_valid && q.size() < 90) begin
        q.push_back(bit_data);
        if (q.size() % 10 == 0) begin
          e_we = 1;
          e_addr = q.size() / 10 - 1;
          e_byte = 0;
          for (int j = 0; j < 8; j++) e_byte[j] = q[q.size() - 8 + j];
        end
      end
      if (line_end && m_act) begin
        bit [7:0] res;
        res = 0;
        for (int k = 0; k < q.size(); k++) res[(89 - k) % 8] ^= q[k];
        e_nc = q.size() < 90;
        e_ce = !e_nc && res != 0;
        e_ok = !e_nc && !e_ce;
        m_act = 0;
        if (search_en && !e_ok)
          e_tgt = (old_tgt >= 40 || old_tgt < 10) ? 10 : old_tgt + 1;
      end
      if (line_start) begin
        m_act = vid_lock && (line_idx == old_tgt);
        q.delete();
      end
      if (!search_en) e_tgt = prog_line;
      e_par = field_even;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (cur_line !== e_tgt[5:0]) begin
        errors++; $display("FAIL R6/R7 cur_line act=%0d exp=%0d", cur_line, e_tgt);
      end
      if (rd_we !== e_we) begin
        errors++; $display("FAIL R2 rd_we act=%0b exp=%0b", rd_we, e_we);
      end else if (rd_we && (rd_addr !== e_addr[3:0] || rd_byte !== e_byte[7:0])) begin
        errors++; $display("FAIL R2 write act=%0d/%h exp=%0d/%h", rd_addr, rd_byte, e_addr, e_byte[7:0]);
      end
      if ({no_code, crc_err, code_ok} !== {e_nc, e_ce, e_ok}) begin
        errors++; $display("FAIL R5 flags act=%b exp=%b", {no_code, crc_err, code_ok}, {e_nc, e_ce, e_ok});
      end
      if (status !== {1'b0, e_par, 3'b000, e_ok, e_ce, e_nc}) begin
        errors++; $display("FAIL R8 status act=%h exp=%h", status, {1'b0, e_par, 3'b000, e_ok, e_ce, e_nc});
      end
      if (rd_we) begin got[rd_addr] = rd_byte; nwrites++; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic build(int seed);
    for (int g = 0; g < 9; g++) begin
      code[g*10] = 1; code[g*10+1] = 0;
      for (int j = 0; j < 8; j++) code[g*10+2+j] = ((seed * 7 + g * 13 + j * 5) % 3) == 0;
    end
    for (int i = 0; i < 8; i++) begin
      bit p;
      p = 0;
      for (int k = 0; k < 82; k++) if ((89 - k) % 8 == 7 - i) p ^= code[k];
      code[82 + i] = p;
    end
  endtask

  task automatic run_line(int ln, bit lock, int nbits, bit tail_on_end);
    @(negedge clk); line_start = 1; line_idx = ln[5:0]; vid_lock = lock;
    @(negedge clk); line_start = 0;
    for (int i = 0; i < nbits; i++) begin
      bit_valid = 1; bit_data = (i < 90) ? code[i] : 1'b1;
      if (tail_on_end && i == nbits - 1) line_end = 1;
      @(negedge clk); bit_valid = 0;
      if (i % 4 == 3) @(negedge clk);
    end
    if (!(tail_on_end && nbits > 0)) begin line_end = 1; @(negedge clk); end
    line_end = 0;
  endtask

  function automatic int exp_byte(int g);
    int b = 0;
    for (int j = 0; j < 8; j++) b |= int'(code[g*10+2+j]) << j;
    return b;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 cur_line", cur_line, 10);
    chk("R10 flags", {no_code, crc_err, code_ok}, 0);
    chk("R10 rd_we", rd_we, 0);

    // R6 manual line, R2 bytes
    prog_line = 14; field_even = 1;
    build(1); nwrites = 0;
    run_line(13, 1, 90, 0);
    chk("R6 other line ignored", nwrites, 0);
    run_line(14, 1, 90, 0);
    chk("R4 good code_ok", code_ok, 1);
    chk("R2 write count", nwrites, 9);
    for (int g = 0; g < 9; g++) chk("R2 byte", got[g], exp_byte(g));
    chk("R8 field bit6", status[6], 1);

    // R4 corrupted check
    build(2); code[35] = ~code[35];
    run_line(14, 1, 90, 0);
    chk("R4 crc_err", crc_err, 1);
    chk("R4 code_ok low", code_ok, 0);

    // R3 truncated line
    build(3);
    run_line(14, 1, 50, 0);
    chk("R3 no_code", no_code, 1);
    chk("R3 crc_err clear", crc_err, 0);

    // R1 no lock: flags hold, no writes
    nwrites = 0;
    run_line(14, 0, 90, 0);
    chk("R1 no write", nwrites, 0);
    chk("R1 flags held", no_code, 1);

    // R9 last bit with line_end, extra bits ignored
    field_even = 0;
    build(4);
    run_line(14, 1, 90, 1);
    chk("R9 same-cycle tail ok", code_ok, 1);
    run_line(14, 1, 95, 0);
    chk("R9 extra bits ignored", code_ok, 1);
    chk("R8 field bit6 odd", status[6], 0);

    // R7 search finds line 17 and stays
    prog_line = 10; @(negedge clk); @(negedge clk);
    search_en = 1;
    build(5);
    for (int ln = 10; ln <= 17; ln++) run_line(ln, 1, (ln == 17) ? 90 : 0, 0);
    chk("R7 found line", cur_line, 17);
    chk("R7 found ok", code_ok, 1);
    for (int ln = 10; ln <= 40; ln++) run_line(ln, 1, (ln == 17) ? 90 : 0, 0);
    chk("R7 stays", cur_line, 17);

    // R7 wrap
    search_en = 0; prog_line = 38; @(negedge clk); @(negedge clk);
    search_en = 1;
    for (int ln = 38; ln <= 40; ln++) run_line(ln, 1, 0, 0);
    chk("R7 wrap to 10", cur_line, 10);
    search_en = 0;

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule